// File: doc/BRIEF.md
# Keyboard Character Queue with CPU Status Port

This block buffers decoded keyboard characters on their way to an 8-bit CPU. A decoder hands it one character at a time through a valid strobe. The CPU reaches the block through four register addresses:

- a data port; reading it takes the oldest character out of the queue;
- a status port holding the empty, full and error flags;
- a count port giving how many characters are waiting;
- a control port that enables the interrupt and clears the error flag.

The CPU can poll the count or status port, or it can wait for the interrupt. The interrupt is raised whenever characters are waiting and software has enabled it.

A character that arrives while the queue is full is thrown away. The stored characters stay as they are, and the event sets a sticky error flag. A CPU access is a single-cycle strobe. Read data is presented combinationally during the strobe cycle, and the state change it causes (a pop) takes effect at the clock edge that ends the strobe. Port map: address 0 data, 1 status, 2 count, 3 control.

Top module: `kbd_char_fifo`

## Requirements
- R1: After reset the queue is empty. Status reads 0x01, count reads 0x00, control reads 0x00 and `irq` is low.
- R2: A read of address 0 returns the oldest stored character and removes it. Characters come out in arrival order, with no separate acknowledge.
- R3: The queue holds at most 16 characters. A character pushed while 16 are stored, with no pop in the same cycle, is discarded. The stored characters and the count are left unchanged.
- R4: A read of address 0 while the queue is empty returns 0x00 and leaves the count unchanged.
- R5: A read of address 2 returns the number of stored characters (0 to 16) in bits 4:0, with bits 7:5 zero.
- R6: A read of address 1 returns the empty flag in bit 0, the full flag in bit 1 and the error flag in bit 2, with bits 7:3 zero.
- R7: A discarded push sets the error flag. The flag stays set until a write to address 3 has bit 1 set. A control write with bit 1 clear leaves the flag set. If a drop and a clear happen in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when control bit 0 (interrupt enable) is 1 and the queue is not empty.
- R9: A push and a data-port pop in the same cycle are both performed, including when the queue is full. The count then stays the same, and the popped value is the oldest character from before that cycle.
- R10: A write to address 3 stores bit 0 as the interrupt enable, and a read of address 3 returns it in bit 0 with the other bits zero. Bit 1 is an action bit and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | One-cycle strobe: key_char is a new character |
| key_char | input | 8 | Character from the keyboard decoder |
| bus_rd | input | 1 | CPU read strobe, one cycle per access |
| bus_wr | input | 1 | CPU write strobe, one cycle per access |
| bus_addr | input | 2 | Register address (0 data, 1 status, 2 count, 3 control) |
| bus_wdata | input | 8 | CPU write data |
| bus_rdata | output | 8 | Read data during bus_rd, 0x00 otherwise |
| irq | output | 1 | Interrupt request |

## Verification
Read data is due in the strobe cycle itself, with no register in the path. The bench therefore samples bus_rdata one time step after it raises bus_rd on a falling edge, before the rising edge that performs the pop. Pushes, pops, flag changes and control writes take effect at the single rising edge inside the strobe, so every later status, count or interrupt check is made on a following falling edge. The simultaneous push-and-pop cases drive both strobes in the same half cycle. The bench then confirms the unchanged count and the order of the entries by draining the queue completely.

// File: rtl/kbdq_pkg.sv
// kbdq_pkg: port addresses and register bit positions shared by the
// keyboard character queue. Assumes a 2-bit register address.
package kbdq_pkg;

    typedef enum logic [1:0] {
        PORT_DATA = 2'd0,
        PORT_STAT = 2'd1,
        PORT_CNT  = 2'd2,
        PORT_CTRL = 2'd3
    } port_e;

    // status port bit positions
    localparam int STAT_EMPTY = 0;
    localparam int STAT_FULL  = 1;
    localparam int STAT_ERR   = 2;

    // control port bit positions
    localparam int CTRL_IEN   = 0;
    localparam int CTRL_CLR   = 1;

endpackage

// File: rtl/kbdq_store.sv
// kbdq_store: circular character storage with read and write pointers
// and an occupancy count.
// Assumes: DEPTH is a power of two; push and pop are single-cycle
// requests. A push while full is performed only if a pop happens in the
// same cycle; otherwise it is reported on 'drop'. A pop while empty is
// ignored.
module kbdq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          drop
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;
    logic          pop_ok;
    logic [DW-1:0] slot_arr [DEPTH];

    // accept decisions for this cycle
    always_comb begin
        pop_ok  = pop_req && (count != '0);
        push_ok = push_req && ((count != FULL_CNT) || pop_ok);
        drop    = push_req && !push_ok;
    end

    // one register per entry, written when the write pointer selects it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] slot_q;

        // capture the pushed character into this entry
        always_ff @(posedge clk) begin
            if (push_ok && (wr_ptr == AW'(i))) begin
                slot_q <= push_data;
            end
        end

        assign slot_arr[i] = slot_q;
    end

    assign head_data = slot_arr[rd_ptr];

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                count <= count + 1'b1;
            end else if (pop_ok && !push_ok) begin
                count <= count - 1'b1;
            end
        end
    end

    // R3: occupancy never exceeds the capacity
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R3: a push into a full queue without a pop changes nothing
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == FULL_CNT && push_req && !pop_req) |=> $stable(count));

    // R4: a pop of an empty queue leaves it empty
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_req && !push_req) |=> (count == '0));

    // R9: push and pop together keep the occupancy
    a_r9_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && count != '0) |=> $stable(count));

endmodule

// File: rtl/kbdq_regs.sv
// kbdq_regs: control register (interrupt enable) and sticky error flag.
// Assumes: ctrl_wr is a one-cycle strobe; the clear bit is an action and
// is not stored; a drop in the same cycle as a clear wins.
module kbdq_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [DW-1:0] ctrl_wdata,
    input  logic          drop,
    output logic          irq_en,
    output logic          err
);

    import kbdq_pkg::*;

    // interrupt enable storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (ctrl_wr) begin
            irq_en <= ctrl_wdata[CTRL_IEN];
        end
    end

    // sticky error: set on drop, cleared by the control clear bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= 1'b0;
        end else if (drop) begin
            err <= 1'b1;
        end else if (ctrl_wr && ctrl_wdata[CTRL_CLR]) begin
            err <= 1'b0;
        end
    end

    // R7: a drop always leaves the error flag set
    a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err);

    // R7: a clear without a simultaneous drop empties the flag
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[CTRL_CLR] && !drop) |=> !err);

    // R7: without drop or clear the flag holds
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!drop && !(ctrl_wr && ctrl_wdata[CTRL_CLR])) |=> $stable(err));

endmodule

// File: rtl/kbd_char_fifo.sv
// kbd_char_fifo: keyboard character queue with data, status, count and
// control ports on an 8-bit CPU register bus, plus an interrupt output.
// Assumes: bus_rd / bus_wr are one-cycle strobes; read data is
// combinational during the strobe; a data-port read pops at the edge
// that ends the strobe.
module kbd_char_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          key_valid,
    input  logic [DW-1:0] key_char,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);

    import kbdq_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic          pop_req;
    logic          ctrl_wr;
    logic [DW-1:0] head_data;
    logic [CW-1:0] count;
    logic          drop;
    logic          irq_en;
    logic          err;
    logic          empty;
    logic          full;

    // bus decode for side-effecting accesses
    always_comb begin
        pop_req = bus_rd && (bus_addr == PORT_DATA);
        ctrl_wr = bus_wr && (bus_addr == PORT_CTRL);
    end

    kbdq_store #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (key_valid),
        .push_data (key_char),
        .pop_req   (pop_req),
        .head_data (head_data),
        .count     (count),
        .drop      (drop)
    );

    kbdq_regs #(
        .DW (DW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (bus_wdata),
        .drop       (drop),
        .irq_en     (irq_en),
        .err        (err)
    );

    assign empty = (count == '0);
    assign full  = (count == FULL_CNT);

    // read data multiplexer, zero outside a read strobe
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                PORT_DATA: bus_rdata = empty ? '0 : head_data;
                PORT_STAT: begin
                    bus_rdata[STAT_EMPTY] = empty;
                    bus_rdata[STAT_FULL]  = full;
                    bus_rdata[STAT_ERR]   = err;
                end
                PORT_CNT:  bus_rdata[CW-1:0] = count;
                PORT_CTRL: bus_rdata[CTRL_IEN] = irq_en;
                default:   bus_rdata = '0;
            endcase
        end
    end

    // interrupt request from the non-empty state
    assign irq = irq_en && !empty;

    // R8: no interrupt while nothing is stored
    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !irq);

    // R4: the data port reads zero while empty
    a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop_req) |-> (bus_rdata == '0));

    // R5: the count port never shows a value beyond capacity
    a_r5_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == PORT_CNT) |-> (bus_rdata <= DW'(DEPTH)));

endmodule

// File: tb/tb_kbd_char_fifo.sv
module tb_kbd_char_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [7:0] key_char = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    kbd_char_fifo dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_char  (key_char),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] c);
        @(negedge clk);
        key_valid = 1'b1;
        key_char  = c;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic push_pop(input logic [7:0] c, output logic [7:0] d);
        @(negedge clk);
        key_valid = 1'b1;
        key_char  = c;
        bus_addr  = 2'd0;
        bus_rd    = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        key_valid = 1'b0;
        bus_rd    = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd1, d); check("R1 status", d, 8'h01);
        rd(2'd2, d); check("R1 count", d, 8'h00);
        rd(2'd3, d); check("R1 control", d, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_order();
        logic [7:0] d;
        push(8'h41); push(8'h42); push(8'h43);
        rd(2'd2, d); check("R5 count three", d, 8'h03);
        rd(2'd1, d); check("R6 status partial", d, 8'h00);
        rd(2'd0, d); check("R2 first", d, 8'h41);
        rd(2'd0, d); check("R2 second", d, 8'h42);
        rd(2'd0, d); check("R2 third", d, 8'h43);
        rd(2'd1, d); check("R6 status drained", d, 8'h01);
    endtask

    task automatic t_empty_read();
        logic [7:0] d;
        rd(2'd0, d); check("R4 empty data", d, 8'h00);
        rd(2'd2, d); check("R4 count after empty read", d, 8'h00);
        push(8'h55);
        rd(2'd0, d); check("R4 pointers intact", d, 8'h55);
    endtask

    task automatic t_overflow();
        logic [7:0] d;
        for (int i = 0; i < 16; i++) push(8'h10 + 8'(i));
        rd(2'd1, d); check("R6 status full", d, 8'h02);
        rd(2'd2, d); check("R5 count sixteen", d, 8'h10);
        push(8'h99);
        rd(2'd1, d); check("R7 error set on drop", d, 8'h06);
        rd(2'd2, d); check("R3 count after drop", d, 8'h10);
        for (int i = 0; i < 16; i++) begin
            rd(2'd0, d); check("R3 stored entries kept", d, 8'h10 + 8'(i));
        end
        rd(2'd1, d); check("R7 error sticky", d, 8'h05);
        wr(2'd3, 8'h00);
        rd(2'd1, d); check("R7 write without clear", d, 8'h05);
        wr(2'd3, 8'h02);
        rd(2'd1, d); check("R7 clear", d, 8'h01);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        push(8'h61);
        @(negedge clk); check("R8 irq disabled", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h03);
        check("R8 irq enabled non-empty", {7'd0, irq}, 8'h01);
        rd(2'd3, d); check("R10 control readback", d, 8'h01);
        rd(2'd0, d); check("R2 irq char", d, 8'h61);
        check("R8 irq low when empty", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'h00);
        push(8'h62);
        @(negedge clk); check("R8 irq after disable", {7'd0, irq}, 8'h00);
        rd(2'd0, d);
    endtask

    task automatic t_push_pop();
        logic [7:0] d;
        push_pop(8'h70, d); check("R9 empty pop value", d, 8'h00);
        rd(2'd2, d); check("R9 push kept on empty pop", d, 8'h01);
        rd(2'd0, d); check("R9 pushed char", d, 8'h70);
        for (int i = 0; i < 16; i++) push(8'h20 + 8'(i));
        push_pop(8'hAA, d); check("R9 full pop value", d, 8'h20);
        rd(2'd1, d); check("R9 full no error", d, 8'h02);
        rd(2'd2, d); check("R9 count kept", d, 8'h10);
        for (int i = 1; i < 16; i++) begin
            rd(2'd0, d); check("R9 drain order", d, 8'h20 + 8'(i));
        end
        rd(2'd0, d); check("R9 new char last", d, 8'hAA);
        rd(2'd1, d); check("R9 empty at end", d, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_empty_read();
        t_overflow();
        t_irq();
        t_push_pop();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule